// File: doc/BRIEF.md
# Code Memory Security Verify Controller

This block sits between a device programmer and an on-chip code store that is modelled as a register array. The programmer presents a byte address, a data byte and a 3-bit operation select. It then strobes an active-low programming line. A write takes effect only after a fixed number of low strobes have been seen with the address, data and operation held steady. A write can go to the code array, to a 64-entry scrambling table, or to one of three sticky security bits.

Read-back works in two ways. A verify read returns the stored code byte XNORed with the table entry picked by the low six address bits. A signature read returns fixed identification bytes. The table has no read path of its own. The security bits tighten access in tiers, and the block reports the result on the execution side. Once any bit is set, code and table writes stop. The first bit also gates table-lookup reads made from external code and freezes the external-access selection captured after reset. The first two bits together block verify. All three together forbid external execution.

The arrays and security bits behave as non-volatile storage. Reset does not clear them. Only the erase input does.

Top module: `codemem_guard`

## Requirements
- R1: A write commits on the clock edge that sees the fifth falling edge of `prog_n_i` while `mode_i` is 1 (code), 2 (table) or 3 (security) and address, data and mode have not changed. Four falling edges or fewer commit nothing.
- R2: Any change of `addr_i`, `data_i` or `mode_i` before the fifth falling edge restarts the count. A falling edge seen in the same cycle as the change counts as the first.
- R3: One cycle of `erase_i` sets every code byte and every table byte to FFh and clears all three security bits.
- R4: With `mode_i` = 4 (verify) and verify not blocked, `vdata_o` one cycle later equals ~(code[addr] ^ table[addr[5:0]]), and `vlock_o` is 0. Erased table entries pass code through unchanged.
- R5: The table is observable only through the XNOR in verify. A table write whose address is 64 or above is ignored.
- R6: While any security bit is set, code and table writes are ignored, but security writes still commit. A security write selects bit 1, 2 or 3 by `addr_i[1:0]` = 1, 2 or 3, and `addr_i[1:0]` = 0 sets nothing.
- R7: With security bits 1 and 2 both set, a verify read returns FFh with `vlock_o` = 1.
- R8: With security bit 1 set and `run_ext_i` = 1, `lut_ok_o` = 0 and `lut_data_o` = FFh. Otherwise `lut_data_o` = code[`lut_addr_i`] combinationally and `lut_ok_o` = 1.
- R9: `ea_pin_i` is captured on the first clock after reset release. While security bit 1 is set, `ea_sel_o` shows that captured value. Otherwise `ea_sel_o` follows `ea_pin_i`.
- R10: `ext_fetch_ok_o` is 0 exactly when all three security bits are set.
- R11: With `mode_i` = 5 (signature), `vdata_o` one cycle later is 15h at address 30h, `DEV_CODE` (B2h by default) at 31h, and FFh elsewhere, whatever the security bits are. Mode values 0, 6 and 7 give FFh.
- R12: During reset and until the first read, `vdata_o` = FFh and `vlock_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| erase_i | input | 1 | Full erase of arrays and security bits |
| prog_n_i | input | 1 | Active-low programming strobe |
| mode_i | input | 3 | 0 idle, 1 code write, 2 table write, 3 security write, 4 verify, 5 signature |
| addr_i | input | ADDR_W | Programmer byte address |
| data_i | input | 8 | Programmer data byte |
| vdata_o | output | 8 | Registered read-back byte |
| vlock_o | output | 1 | Verify refused by security |
| ea_pin_i | input | 1 | External-access selection pin |
| run_ext_i | input | 1 | Core currently executing external code |
| lut_addr_i | input | ADDR_W | Table-lookup read address from the core |
| lut_data_o | output | 8 | Table-lookup read data |
| lut_ok_o | output | 1 | Lookup allowed |
| ea_sel_o | output | 1 | Effective external-access selection |
| ext_fetch_ok_o | output | 1 | External program execution allowed |

## Verification
The bench targets the strobe counter's edges. It gives a run of exactly four falls, and it changes the data just before the fifth fall. A counter that is off by one or never clears would commit a byte that must stay erased. It writes the table at an address of 64 or above, which aliases onto a live entry. A design that drops the range check would change an existing verify result. It sets the security bits one at a time and checks each tier. A lock applied one tier too early or too late shows up as wrong code, table or verify behaviour. It resets again with the opposite pin level. A capture that is not frozen by bit 1, or not taken after reset, would make `ea_sel_o` follow the pin.

// File: rtl/cmg_pkg.sv
package cmg_pkg;
  typedef enum logic [2:0] {
    M_IDLE  = 3'd0,
    M_PCODE = 3'd1,
    M_PTAB  = 3'd2,
    M_PSEC  = 3'd3,
    M_VFY   = 3'd4,
    M_SIG   = 3'd5
  } op_e;

  localparam logic [7:0] BLANK    = 8'hFF;
  localparam logic [7:0] MFR_BYTE = 8'h15;
  localparam int         SIG_LOC0 = 'h30;
  localparam int         SIG_LOC1 = 'h31;
endpackage

// File: rtl/cmg_strobe.sv
module cmg_strobe #(
  parameter int PULSES = 5,
  parameter int KEY_W  = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_n_i,
  input  logic             arm_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             commit_o
);
  localparam int CNT_W = $clog2(PULSES + 1);

  logic             prog_q;
  logic [KEY_W-1:0] key_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fall, moved;

  assign fall  = prog_q & ~prog_n_i;
  assign moved = (key_i != key_q);

  always_comb begin
    cnt_d    = cnt_q;
    commit_o = 1'b0;
    if (!arm_i) begin
      cnt_d = '0;
    end else if (moved) begin
      cnt_d = fall ? CNT_W'(1) : '0;
    end else if (fall) begin
      if (cnt_q == CNT_W'(PULSES - 1)) begin
        cnt_d    = '0;
        commit_o = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= 1'b1;
      key_q  <= '0;
      cnt_q  <= '0;
    end else begin
      prog_q <= prog_n_i;
      key_q  <= key_i;
      cnt_q  <= cnt_d;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(PULSES)) else $error("count out of range"); // R1
  AST_COMMIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> (cnt_q == '0)) else $error("count not cleared after commit"); // R1
  AST_CHANGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && moved) |=> (cnt_q <= CNT_W'(1))) else $error("partial count survived change"); // R2
endmodule

// File: rtl/cmg_store.sv
module cmg_store
  import cmg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ENC_DEPTH = 64
) (
  input  logic              clk,
  input  logic              erase_i,
  input  logic              code_we_i,
  input  logic              tab_we_i,
  input  logic [2:0]        sec_set_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  output logic [7:0]        vcode_o,
  output logic [7:0]        vtab_o,
  input  logic [ADDR_W-1:0] laddr_i,
  output logic [7:0]        lcode_o,
  output logic [2:0]        sec_o
);
  localparam int CODE_DEPTH = 1 << ADDR_W;
  localparam int ENC_W      = $clog2(ENC_DEPTH);

  logic [7:0] code_mem [CODE_DEPTH];
  logic [7:0] tab_mem  [ENC_DEPTH];
  logic [2:0] sec_q;

  // Non-volatile cells: no reset, cleared only by erase.
  always_ff @(posedge clk) begin
    if (erase_i) begin
      for (int i = 0; i < CODE_DEPTH; i++) code_mem[i] <= BLANK;
      for (int j = 0; j < ENC_DEPTH; j++)  tab_mem[j]  <= BLANK;
      sec_q <= '0;
    end else begin
      if (code_we_i) code_mem[waddr_i] <= wdata_i;
      if (tab_we_i)  tab_mem[waddr_i[ENC_W-1:0]] <= wdata_i;
      sec_q <= sec_q | sec_set_i;
    end
  end

  assign vcode_o = code_mem[vaddr_i];
  assign vtab_o  = tab_mem[vaddr_i[ENC_W-1:0]];
  assign lcode_o = code_mem[laddr_i];
  assign sec_o   = sec_q;
endmodule

// File: rtl/cmg_readout.sv
module cmg_readout
  import cmg_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] DEV_CODE = 8'hB2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        code_i,
  input  logic [7:0]        tab_i,
  input  logic              block_i,
  output logic [7:0]        vdata_o,
  output logic              vlock_o
);
  logic [7:0] vd_d;
  logic       vl_d;

  always_comb begin
    vd_d = BLANK;
    vl_d = 1'b0;
    case (op_e'(mode_i))
      M_VFY: begin
        if (block_i) vl_d = 1'b1;
        else         vd_d = ~(code_i ^ tab_i);
      end
      M_SIG: begin
        if (addr_i == ADDR_W'(SIG_LOC0))      vd_d = MFR_BYTE;
        else if (addr_i == ADDR_W'(SIG_LOC1)) vd_d = DEV_CODE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vdata_o <= BLANK;
      vlock_o <= 1'b0;
    end else begin
      vdata_o <= vd_d;
      vlock_o <= vl_d;
    end
  end

  AST_LOCK_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
    vlock_o |-> (vdata_o == BLANK)) else $error("locked verify leaked data"); // R7
  AST_BLOCK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == M_VFY && block_i) |=> vlock_o) else $error("lock flag missing"); // R7
  AST_SIG_MFR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == M_SIG && addr_i == ADDR_W'(SIG_LOC0)) |=> (vdata_o == MFR_BYTE))
    else $error("signature byte wrong"); // R11
endmodule

// File: rtl/codemem_guard.sv
module codemem_guard
  import cmg_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         ENC_DEPTH = 64,
  parameter int         PULSES    = 5,
  parameter logic [7:0] DEV_CODE  = 8'hB2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_i,
  input  logic              prog_n_i,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        vdata_o,
  output logic              vlock_o,
  input  logic              ea_pin_i,
  input  logic              run_ext_i,
  input  logic [ADDR_W-1:0] lut_addr_i,
  output logic [7:0]        lut_data_o,
  output logic              lut_ok_o,
  output logic              ea_sel_o,
  output logic              ext_fetch_ok_o
);
  localparam int ENC_W = $clog2(ENC_DEPTH);
  localparam int KEY_W = 3 + ADDR_W + 8;

  logic             arm, commit, unlocked, tab_in_range;
  logic             code_we, tab_we, vfy_block;
  logic [2:0]       sec, sec_set;
  logic [7:0]       vcode, vtab, lcode;
  logic             armed_q, armed_d, ea_lat_q, ea_lat_d;

  assign arm = (mode_i == M_PCODE) || (mode_i == M_PTAB) || (mode_i == M_PSEC);

  cmg_strobe #(.PULSES(PULSES), .KEY_W(KEY_W)) u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_n_i (prog_n_i),
    .arm_i    (arm),
    .key_i    ({mode_i, addr_i, data_i}),
    .commit_o (commit)
  );

  // Write policy
  assign unlocked     = (sec == 3'b000);
  assign tab_in_range = ((addr_i >> ENC_W) == '0);
  assign code_we      = commit && (mode_i == M_PCODE) && unlocked;
  assign tab_we       = commit && (mode_i == M_PTAB) && unlocked && tab_in_range;

  always_comb begin
    sec_set = 3'b000;
    if (commit && (mode_i == M_PSEC)) begin
      case (addr_i[1:0])
        2'd1:    sec_set = 3'b001;
        2'd2:    sec_set = 3'b010;
        2'd3:    sec_set = 3'b100;
        default: sec_set = 3'b000;
      endcase
    end
  end

  cmg_store #(.ADDR_W(ADDR_W), .ENC_DEPTH(ENC_DEPTH)) u_store (
    .clk       (clk),
    .erase_i   (erase_i),
    .code_we_i (code_we),
    .tab_we_i  (tab_we),
    .sec_set_i (sec_set),
    .waddr_i   (addr_i),
    .wdata_i   (data_i),
    .vaddr_i   (addr_i),
    .vcode_o   (vcode),
    .vtab_o    (vtab),
    .laddr_i   (lut_addr_i),
    .lcode_o   (lcode),
    .sec_o     (sec)
  );

  assign vfy_block = sec[0] & sec[1];

  cmg_readout #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_readout (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .addr_i  (addr_i),
    .code_i  (vcode),
    .tab_i   (vtab),
    .block_i (vfy_block),
    .vdata_o (vdata_o),
    .vlock_o (vlock_o)
  );

  // External-access capture after reset
  always_comb begin
    armed_d  = armed_q;
    ea_lat_d = ea_lat_q;
    if (!armed_q) begin
      armed_d  = 1'b1;
      ea_lat_d = ea_pin_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      ea_lat_q <= 1'b0;
    end else begin
      armed_q  <= armed_d;
      ea_lat_q <= ea_lat_d;
    end
  end

  assign ea_sel_o       = (sec[0] && armed_q) ? ea_lat_q : ea_pin_i;
  assign ext_fetch_ok_o = ~(&sec);
  assign lut_ok_o       = ~(sec[0] & run_ext_i);
  assign lut_data_o     = lut_ok_o ? lcode : BLANK;

  AST_SEC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_i |=> ((sec & $past(sec)) == $past(sec))) else $error("security bit cleared"); // R6
  AST_LOCKED_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (sec != 3'b000) |-> (!code_we && !tab_we)) else $error("write while locked"); // R6
  AST_EA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sec[0] && armed_q && !erase_i) |=> $stable(ea_sel_o)) else $error("ea selection moved"); // R9
  AST_LUT_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    !lut_ok_o |-> (lut_data_o == BLANK)) else $error("lookup leaked data"); // R8
endmodule

// File: tb/codemem_guard_test.sv
module codemem_guard_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, erase, prog_n, ea_pin, run_ext;
  logic [2:0] mode;
  logic [7:0] addr, data, lut_addr;
  logic [7:0] vdata, lut_data;
  logic       vlock, lut_ok, ea_sel, ext_ok;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codemem_guard uut (
    .clk (clk), .rst_n (rst_n), .erase_i (erase), .prog_n_i (prog_n),
    .mode_i (mode), .addr_i (addr), .data_i (data),
    .vdata_o (vdata), .vlock_o (vlock),
    .ea_pin_i (ea_pin), .run_ext_i (run_ext), .lut_addr_i (lut_addr),
    .lut_data_o (lut_data), .lut_ok_o (lut_ok),
    .ea_sel_o (ea_sel), .ext_fetch_ok_o (ext_ok)
  );

  // Behavioural reference
  logic [7:0] m_code [256];
  logic [7:0] m_tab  [64];
  bit s1, s2, s3;
  bit m_prev, m_armed, m_ea;
  int m_cnt;
  logic [18:0] m_last;
  logic [7:0] exp_vd;
  bit exp_vl;

  always @(posedge clk or negedge rst_n) begin
    bit fall, commit;
    logic [18:0] key;
    if (erase) begin
      for (int i = 0; i < 256; i++) m_code[i] = 8'hFF;
      for (int i = 0; i < 64; i++) m_tab[i] = 8'hFF;
      s1 = 0; s2 = 0; s3 = 0;
    end
    if (!rst_n) begin
      m_prev = 1; m_last = '0; m_cnt = 0; m_armed = 0; m_ea = 0;
      exp_vd = 8'hFF; exp_vl = 0;
    end else begin
      exp_vd = 8'hFF; exp_vl = 0;
      if (mode == 4) begin
        if (s1 && s2) exp_vl = 1;
        else exp_vd = ~(m_code[addr] ^ m_tab[addr % 64]);
      end else if (mode == 5) begin
        if (addr == 8'h30) exp_vd = 8'h15;
        else if (addr == 8'h31) exp_vd = 8'hB2;
      end
      fall = m_prev && !prog_n;
      key = {mode, addr, data};
      commit = 0;
      if (!(mode == 1 || mode == 2 || mode == 3)) m_cnt = 0;
      else if (key != m_last) m_cnt = fall ? 1 : 0;
      else if (fall) begin
        m_cnt++;
        if (m_cnt == 5) begin m_cnt = 0; commit = 1; end
      end
      m_prev = prog_n;
      m_last = key;
      if (!m_armed) begin m_armed = 1; m_ea = ea_pin; end
      if (commit && !erase) begin
        if (mode == 1 && !(s1 || s2 || s3)) m_code[addr] = data;
        if (mode == 2 && !(s1 || s2 || s3) && addr < 64) m_tab[addr] = data;
        if (mode == 3) begin
          if (addr % 4 == 1) s1 = 1;
          if (addr % 4 == 2) s2 = 1;
          if (addr % 4 == 3) s3 = 1;
        end
      end
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
    check(mode == 5 ? "R11" : (mode == 4 && s1 && s2) ? "R7" : (rst_n ? "R4" : "R12"), vdata, exp_vd);
    check(mode == 4 && s1 && s2 ? "R7" : "R12", {7'd0, vlock}, {7'd0, exp_vl});
    check("R8", lut_data, (s1 && run_ext) ? 8'hFF : m_code[lut_addr]);
    check("R8", {7'd0, lut_ok}, {7'd0, !(s1 && run_ext)});
    check("R9", {7'd0, ea_sel}, {7'd0, (s1 && m_armed) ? m_ea : ea_pin});
    check("R10", {7'd0, ext_ok}, {7'd0, !(s1 && s2 && s3)});
  endtask

  task automatic pulses(int n);
    for (int k = 0; k < n; k++) begin
      prog_n = 0; cyc();
      prog_n = 1; cyc();
    end
  endtask

  task automatic wr(logic [2:0] m, logic [7:0] a, logic [7:0] d);
    mode = m; addr = a; data = d;
    pulses(5);
  endtask

  task automatic vfy(logic [7:0] a, logic [7:0] exp, string tag);
    mode = 4; addr = a; cyc();
    check(tag, vdata, exp);
  endtask

  initial begin
    rst_n = 0; erase = 1; prog_n = 1; mode = 0; addr = 0; data = 0;
    ea_pin = 1; run_ext = 0; lut_addr = 0;
    cyc(); cyc();
    check("R12", vdata, 8'hFF);
    check("R12", {7'd0, vlock}, 8'd0);
    erase = 0; cyc();
    rst_n = 1; cyc();
    check("R12", vdata, 8'hFF);
    vfy(8'h10, 8'hFF, "R3");

    wr(3'd1, 8'h10, 8'h5A);
    vfy(8'h10, 8'h5A, "R1");
    mode = 1; addr = 8'h11; data = 8'h33; pulses(4);
    vfy(8'h11, 8'hFF, "R1");
    mode = 1; addr = 8'h11; data = 8'h33; pulses(4);
    data = 8'h44; pulses(1);
    vfy(8'h11, 8'hFF, "R2");
    wr(3'd1, 8'h11, 8'h44);
    vfy(8'h11, 8'h44, "R2");

    wr(3'd2, 8'h10, 8'h0F);
    vfy(8'h10, 8'hAA, "R4");
    vfy(8'h11, 8'h44, "R4");
    wr(3'd2, 8'h50, 8'h00);
    vfy(8'h10, 8'hAA, "R5");
    vfy(8'h50, 8'h0F, "R5");

    mode = 5; addr = 8'h30; cyc(); check("R11", vdata, 8'h15);
    addr = 8'h31; cyc(); check("R11", vdata, 8'hB2);
    addr = 8'h32; cyc(); check("R11", vdata, 8'hFF);
    mode = 6; addr = 8'h10; cyc(); check("R11", vdata, 8'hFF);

    mode = 0; run_ext = 1; lut_addr = 8'h10; cyc();
    check("R8", lut_data, 8'h5A);

    wr(3'd3, 8'h00, 8'h00);
    wr(3'd1, 8'h12, 8'h77);
    vfy(8'h12, 8'h77, "R6");
    check("R10", {7'd0, ext_ok}, 8'd1);
    wr(3'd3, 8'h01, 8'h00);
    wr(3'd1, 8'h13, 8'h66);
    vfy(8'h13, 8'hFF, "R6");
    wr(3'd2, 8'h12, 8'h00);
    vfy(8'h12, 8'h77, "R6");
    mode = 0; run_ext = 1; cyc();
    check("R8", lut_data, 8'hFF);
    check("R8", {7'd0, lut_ok}, 8'd0);
    run_ext = 0; cyc();
    check("R8", lut_data, 8'h5A);

    ea_pin = 0; cyc();
    check("R9", {7'd0, ea_sel}, 8'd1);
    rst_n = 0; cyc();
    rst_n = 1; cyc();
    ea_pin = 1; cyc();
    check("R9", {7'd0, ea_sel}, 8'd0);
    vfy(8'h10, 8'hAA, "R9");

    wr(3'd3, 8'h02, 8'h00);
    vfy(8'h10, 8'hFF, "R7");
    check("R7", {7'd0, vlock}, 8'd1);
    mode = 5; addr = 8'h30; cyc(); check("R11", vdata, 8'h15);
    check("R10", {7'd0, ext_ok}, 8'd1);
    wr(3'd3, 8'h03, 8'h00);
    check("R10", {7'd0, ext_ok}, 8'd0);

    mode = 0; erase = 1; cyc();
    erase = 0; cyc();
    check("R3", {7'd0, ext_ok}, 8'd1);
    vfy(8'h10, 8'hFF, "R3");
    check("R3", {7'd0, vlock}, 8'd0);
    wr(3'd1, 8'h10, 8'hC3);
    vfy(8'h10, 8'hC3, "R3");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule